// File: doc/BRIEF.md
# Byte-Lane Bus Width Adapter

This block sits between a requester that addresses individual bytes and a memory or peripheral port that is 16 or 32 bits wide and has no low address lines. Each request carries a byte address, an access size (byte, halfword or word), a write flag and write data. The block sends one aligned request to the memory side. That request carries a word offset, which is the byte address shifted right by the number of low address bits the bus width removes, and a per-lane enable mask. The offset can therefore index word storage directly.

Lanes follow big-endian order. The byte at the lowest address within a word sits in the most significant lane. On writes, the requester's low byte or low halfword is copied onto every lane, so whichever lanes are enabled carry the right value. Read data comes back from the memory one cycle after the request. The block shifts the selected lanes down to bit 0 and fills the unused upper bits with zeros. A multi-byte access that is not naturally aligned, or a size code the bus cannot carry, is never split. It raises an error pulse and no request goes to the memory side.

Top module: `lane_adapter`

## Requirements
- R1: `mem_off` equals `req_addr` shifted right by log2(BUS_W/8): 2 bits for the default 32-bit bus, so byte address 0x0030 gives offset 0x000C.
- R2: A valid byte access (`req_size` = 0) at byte position b = `req_addr[1:0]` enables only lane bit 3-b of `mem_lane_en`. Lane bit k covers data bits [8k+7:8k], so position 0 maps to bits 31:24.
- R3: A valid halfword access (`req_size` = 1) with `req_addr[0]` = 0 enables two lanes. Position 0 enables lanes 3 and 2 (mask 1100). Position 2 enables lanes 1 and 0 (mask 0011).
- R4: A valid word access (`req_size` = 2) with `req_addr[1:0]` = 0 enables all four lanes in one request.
- R5: A halfword with address bit 0 set, a word with address bits 1:0 not both zero, or size code 3 raises `misalign` for that cycle. In that case `mem_valid` is low and `mem_lane_en` is 0.
- R6: `mem_wdata` is `req_wdata[7:0]` copied to all four lanes for a byte access, `req_wdata[15:0]` copied to both halves for a halfword, and `req_wdata` unchanged for a word. Upper requester bits are ignored for narrow sizes.
- R7: For an accepted read, in the next cycle `rsp_valid` is 1 and `rsp_rdata` holds the enabled lanes of `mem_rdata`, right-justified and zero-filled. For example, memory word 0x12345678 gives 0x12 for a byte read at position 0, 0x34 at position 1, and 0x5678 for a halfword read at position 2.
- R8: After reset, and in any cycle that does not follow an accepted read, `rsp_valid` is 0 and `rsp_rdata` is 0. This includes cycles after writes and after misaligned requests.
- R9: When `req_valid` is low, `mem_valid`, `mem_lane_en` and `misalign` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | BUS_W | Write data, right-justified |
| mem_valid | output | 1 | Aligned request to the memory side |
| mem_write | output | 1 | Memory-side write flag |
| mem_off | output | ADDR_W-log2(BUS_W/8) | Word offset |
| mem_lane_en | output | BUS_W/8 | Per-byte lane enables, bit k = data bits [8k+7:8k] |
| mem_wdata | output | BUS_W | Lane-replicated write data |
| mem_rdata | input | BUS_W | Memory read data, one cycle after the request |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | BUS_W | Right-justified, zero-filled read data |
| misalign | output | 1 | Error pulse for a misaligned or invalid request |

## Verification
On every cycle, the assertions check the shape of the lane mask: one lane for bytes, two for halfwords, all four for words, none on an error or when idle. They also check that a response appears only one cycle after an accepted read. Only the bench scenarios show that the lane chosen matches the big-endian byte position, that offsets and replicated write data carry the expected values, and that the returned read bytes are the right ones, correctly shifted and zero-filled.

// File: rtl/lane_adapter.sv
module lane_adapter #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid,
  input  logic                                    req_write,
  input  logic [1:0]                              req_size,
  input  logic [ADDR_W-1:0]                       req_addr,
  input  logic [BUS_W-1:0]                        req_wdata,
  output logic                                    mem_valid,
  output logic                                    mem_write,
  output logic [ADDR_W-$clog2(BUS_W/8)-1:0]       mem_off,
  output logic [BUS_W/8-1:0]                      mem_lane_en,
  output logic [BUS_W-1:0]                        mem_wdata,
  input  logic [BUS_W-1:0]                        mem_rdata,
  output logic                                    rsp_valid,
  output logic [BUS_W-1:0]                        rsp_rdata,
  output logic                                    misalign
);
  localparam int NL   = BUS_W / 8;
  localparam int LB   = $clog2(NL);
  localparam int SH_W = $clog2(BUS_W);

  logic [LB-1:0]    bpos;
  logic             bad;
  logic [NL-1:0]    lanes;
  logic [SH_W-1:0]  shamt, shamt_q;
  logic [BUS_W-1:0] rmask, rmask_q;
  logic [BUS_W-1:0] wrep;
  logic             rd_q;

  assign bpos = req_addr[LB-1:0];

  always_comb begin
    int nb, lo, bp;
    bp = int'(bpos);
    case (req_size)
      2'd0:    nb = 1;
      2'd1:    nb = 2;
      2'd2:    nb = 4;
      default: nb = 0;
    endcase
    bad   = (nb == 0) || (nb > NL) || ((bp % (nb == 0 ? 1 : nb)) != 0);
    lanes = '0;
    shamt = '0;
    rmask = '0;
    if (!bad) begin
      lo    = NL - nb - bp;
      shamt = SH_W'(8 * lo);
      for (int i = 0; i < NL; i++) begin
        if (i >= lo && i < lo + nb) lanes[i] = 1'b1;
        if (i < nb) rmask[8*i +: 8] = 8'hFF;
      end
    end
    for (int i = 0; i < NL; i++) begin
      case (nb)
        1:       wrep[8*i +: 8] = req_wdata[7:0];
        2:       wrep[8*i +: 8] = req_wdata[8*(i%2) +: 8];
        default: wrep[8*i +: 8] = req_wdata[8*i +: 8];
      endcase
    end
  end

  assign mem_valid   = req_valid & ~bad;
  assign mem_write   = req_write;
  assign mem_off     = req_addr[ADDR_W-1:LB];
  assign mem_lane_en = req_valid ? lanes : '0;
  assign mem_wdata   = wrep;
  assign misalign    = req_valid & bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      shamt_q <= '0;
      rmask_q <= '0;
    end else begin
      rd_q <= mem_valid & ~req_write;
      if (mem_valid && !req_write) begin
        shamt_q <= shamt;
        rmask_q <= rmask;
      end
    end
  end

  assign rsp_valid = rd_q;
  assign rsp_rdata = rd_q ? ((mem_rdata >> shamt_q) & rmask_q) : '0;

  // R5
  err_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_valid && mem_lane_en == '0));
  // R2
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_size == 2'd0) |-> $countones(mem_lane_en) == 1);
  // R3
  half_two_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_size == 2'd1) |-> $countones(mem_lane_en) == 2);
  // R4
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_size == 2'd2) |-> mem_lane_en == '1);
  // R7
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_valid && !mem_write));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_valid && mem_lane_en == '0 && !misalign));
endmodule

// File: tb/tb_lane_adapter.sv
module tb_lane_adapter;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_size = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0, mem_rdata = 0;
  logic        mem_valid, mem_write, rsp_valid, misalign;
  logic [13:0] mem_off;
  logic [3:0]  mem_lane_en;
  logic [31:0] mem_wdata, rsp_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  lane_adapter dut (.*);

  typedef struct packed {
    logic        wr;  logic [1:0] sz; logic [15:0] addr; logic [31:0] wd;
    logic [31:0] mrd; logic [13:0] off; logic [3:0] ln; logic [31:0] mwd;
    logic        err; logic [31:0] rd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{1'b0, 2'd0, 16'h0030, 32'h0, 32'h12345678, 14'h000C, 4'b1000, 32'h0, 1'b0, 32'h12},
    '{1'b0, 2'd0, 16'h0031, 32'h0, 32'h12345678, 14'h000C, 4'b0100, 32'h0, 1'b0, 32'h34},
    '{1'b0, 2'd0, 16'h0032, 32'h0, 32'h12345678, 14'h000C, 4'b0010, 32'h0, 1'b0, 32'h56},
    '{1'b0, 2'd0, 16'h0033, 32'h0, 32'h12345678, 14'h000C, 4'b0001, 32'h0, 1'b0, 32'h78},
    '{1'b0, 2'd1, 16'h0030, 32'h0, 32'h12345678, 14'h000C, 4'b1100, 32'h0, 1'b0, 32'h1234},
    '{1'b0, 2'd1, 16'h0032, 32'h0, 32'h12345678, 14'h000C, 4'b0011, 32'h0, 1'b0, 32'h5678},
    '{1'b0, 2'd2, 16'h0034, 32'h0, 32'h9ABCDEF0, 14'h000D, 4'b1111, 32'h0, 1'b0, 32'h9ABCDEF0},
    '{1'b1, 2'd0, 16'h0105, 32'hFFFFFFAB, 32'h0, 14'h0041, 4'b0100, 32'hABABABAB, 1'b0, 32'h0},
    '{1'b1, 2'd1, 16'h0102, 32'hFFFF1234, 32'h0, 14'h0040, 4'b0011, 32'h12341234, 1'b0, 32'h0},
    '{1'b1, 2'd2, 16'h0FFC, 32'hCAFEF00D, 32'h0, 14'h03FF, 4'b1111, 32'hCAFEF00D, 1'b0, 32'h0},
    '{1'b0, 2'd1, 16'h0031, 32'h0, 32'h12345678, 14'h000C, 4'b0000, 32'h0, 1'b1, 32'h0},
    '{1'b1, 2'd2, 16'h0102, 32'h55667788, 32'h0, 14'h0040, 4'b0000, 32'h55667788, 1'b1, 32'h0},
    '{1'b0, 2'd3, 16'h0000, 32'h0, 32'h12345678, 14'h0000, 4'b0000, 32'h0, 1'b1, 32'h0},
    '{1'b0, 2'd0, 16'hFFFF, 32'h0, 32'h11223344, 14'h3FFF, 4'b0001, 32'h0, 1'b0, 32'h44},
    '{1'b0, 2'd2, 16'hFFFC, 32'h0, 32'h80000001, 14'h3FFF, 4'b1111, 32'h0, 1'b0, 32'h80000001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R8 reset rsp_rdata", rsp_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    req_addr = 16'h0031; req_size = 2'd0; req_valid = 0;
    #1;
    chk("R9 idle mem_valid", 32'(mem_valid), 0);
    chk("R9 idle lanes", 32'(mem_lane_en), 0);
    chk("R9 idle misalign", 32'(misalign), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1; req_write = VT[i].wr; req_size = VT[i].sz;
      req_addr = VT[i].addr; req_wdata = VT[i].wd; mem_rdata = 32'hDEADBEEF;
      #1;
      chk("R1 offset", 32'(mem_off), 32'(VT[i].off));
      chk(VT[i].sz == 0 ? "R2 byte lanes" : VT[i].sz == 1 ? "R3 half lanes" :
          VT[i].sz == 2 ? "R4 word lanes" : "R5 invalid lanes", 32'(mem_lane_en), 32'(VT[i].ln));
      chk("R5 misalign", 32'(misalign), 32'(VT[i].err));
      chk("R5 mem_valid", 32'(mem_valid), 32'(!VT[i].err));
      if (!VT[i].err) chk("R1 mem_write", 32'(mem_write), 32'(VT[i].wr));
      if (VT[i].wr) chk("R6 write data", mem_wdata, VT[i].mwd);
      @(negedge clk);
      req_valid = 0; mem_rdata = VT[i].mrd;
      #1;
      if (!VT[i].wr && !VT[i].err) begin
        chk("R7 rsp_valid", 32'(rsp_valid), 1);
        chk("R7 rsp_rdata", rsp_rdata, VT[i].rd);
      end else begin
        chk("R8 no response", 32'(rsp_valid), 0);
        chk("R8 rsp_rdata zero", rsp_rdata, 0);
      end
    end

    // R7 back-to-back reads: second response uses its own lane selection
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 2'd0; req_addr = 16'h0200;
    @(negedge clk);
    mem_rdata = 32'hA1B2C3D4; req_size = 2'd1; req_addr = 16'h0202;
    #1;
    chk("R7 b2b first", rsp_rdata, 32'hA1);
    @(negedge clk);
    req_valid = 0; mem_rdata = 32'hA1B2C3D4;
    #1;
    chk("R7 b2b second", rsp_rdata, 32'hC3D4);
    @(negedge clk);
    #1;
    chk("R8 idle after read", 32'(rsp_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule